// File: doc/BRIEF.md
# Hardware Multiply-Accumulate Peripheral

This block is a multiplier that sits on a 16-bit register bus. Software chooses the operation by picking the operand-1 address it writes. The four choices are unsigned multiply, signed multiply, unsigned accumulate and signed accumulate. A write of operand 2 then runs the selected operation in that same clock edge. The 32-bit result, the accumulator and a mode-dependent sum-extension word can be read back on the next cycle.

A second set of registers performs a 32x32 multiply with a 64-bit product. Operand 1 is signed or unsigned depending on which low-word address receives it. The multiply runs when the high word of operand 2 is written, and the product is read back as four 16-bit words. Writing the low result register preloads the 16-bit accumulator path. Reads have no wait states: the read data is a combinational function of the stored state.

Top module: `mac_periph`

## Requirements
- R1: Only word accesses (bus_word=1) whose address lies in 0x130..0x15B reach the unit. Byte accesses and addresses outside that window change no state and read 0.
- R2: A write to 0x130, 0x132, 0x134 or 0x136 stores operand 1 and sets the mode to unsigned multiply, signed multiply, unsigned accumulate or signed accumulate respectively. Any of the four addresses reads back operand 1.
- R3: A write to 0x138 stores operand 2 and runs the current mode's operation. From the next cycle the result reads at 0x13A (bits 15:0) and 0x13C (bits 31:16).
- R4: In both multiply modes the result becomes the 32-bit product and the accumulator becomes 0. Signed multiply treats both operands as two's complement.
- R5: In both accumulate modes the product is added to the accumulator, with the sum wrapping at 32 bits. The sum becomes both the new accumulator and the new result. Signed accumulate sign-extends both operands.
- R6: The word at 0x13E reads as follows. Unsigned multiply gives 0. Signed multiply gives 0xFFFF when the result is negative, else 0. Signed accumulate gives 0xFFFF when the accumulator is negative, else 0. Unsigned accumulate gives the carry out of the last accumulate (0 or 1).
- R7: A write to 0x13A loads both result and accumulator with the 16-bit value. The value is zero-extended in unsigned modes and sign-extended in signed modes.
- R8: For the 32-bit multiply, 0x140 and 0x144 load the low word of operand 1 and clear its high word. 0x140 selects unsigned 64-bit mode and 0x144 selects signed 64-bit mode. Both 0x142 and 0x146 replace bits 31:16 of operand 1. 0x148 loads the low word of operand 2 and clears its high word.
- R9: A write to 0x14A replaces bits 31:16 of operand 2 and computes the 64-bit product, signed or unsigned as selected. The product reads at 0x14C, 0x14E, 0x150 and 0x152, least significant word first.
- R10: Addresses inside the window that map to no register read 0, and writes to them are ignored. Writes to the read-only words 0x13C, 0x13E and 0x14C..0x152 are ignored.
- R11: After reset every register is 0 and the mode is unsigned multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |

## Verification
The bench runs two unsigned accumulates that push the 32-bit sum past its top bit. A design that drops the stored carry, or reports the accumulator sign in unsigned accumulate mode, reads the wrong sum-extension word. Preloads of 0x8000 in a signed and in an unsigned mode separate sign extension from zero extension. A multiply followed by an accumulate shows whether the multiply cleared the accumulator: a design that adds to the old result returns a wrong sum. The 32-bit tests mix a signed -1 with a small operand, and also rewrite a low word after the high word has been set, to catch sign handling and high-word clearing errors.

// File: rtl/mac_periph_pkg.sv
package mac_periph_pkg;

    typedef enum logic [1:0] {
        MODE_UMUL = 2'd0,
        MODE_SMUL = 2'd1,
        MODE_UMAC = 2'd2,
        MODE_SMAC = 2'd3
    } mpy_mode_e;

    typedef struct packed {
        logic op1;
        logic op2;
        logic rlo;
        logic w1lo;
        logic w1hi;
        logic w2lo;
        logic w2hi;
    } wr_strobe_t;

    localparam logic [3:0] RS_NONE = 4'd0;
    localparam logic [3:0] RS_OP1  = 4'd1;
    localparam logic [3:0] RS_OP2  = 4'd2;
    localparam logic [3:0] RS_RLO  = 4'd3;
    localparam logic [3:0] RS_RHI  = 4'd4;
    localparam logic [3:0] RS_SUMX = 4'd5;
    localparam logic [3:0] RS_W1LO = 4'd6;
    localparam logic [3:0] RS_W1HI = 4'd7;
    localparam logic [3:0] RS_W2LO = 4'd8;
    localparam logic [3:0] RS_W2HI = 4'd9;
    localparam logic [3:0] RS_P0   = 4'd10;

    function automatic logic mode_is_signed(mpy_mode_e m);
        return m[0];
    endfunction

    function automatic logic mode_is_mac(mpy_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/mac_periph_decode.sv
module mac_periph_decode
    import mac_periph_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] WIN_LO  = 16'h0130,
    parameter logic [ADDR_W-1:0] WIN_HI  = 16'h015B,
    parameter logic [ADDR_W-1:0] A_OP1   = 16'h0130,
    parameter logic [ADDR_W-1:0] A_OP2   = 16'h0138,
    parameter logic [ADDR_W-1:0] A_RLO   = 16'h013A,
    parameter logic [ADDR_W-1:0] A_RHI   = 16'h013C,
    parameter logic [ADDR_W-1:0] A_SUMX  = 16'h013E,
    parameter logic [ADDR_W-1:0] A_W1LOU = 16'h0140,
    parameter logic [ADDR_W-1:0] A_W1HIU = 16'h0142,
    parameter logic [ADDR_W-1:0] A_W1LOS = 16'h0144,
    parameter logic [ADDR_W-1:0] A_W1HIS = 16'h0146,
    parameter logic [ADDR_W-1:0] A_W2LO  = 16'h0148,
    parameter logic [ADDR_W-1:0] A_W2HI  = 16'h014A,
    parameter logic [ADDR_W-1:0] A_PROD  = 16'h014C
) (
    input  logic              sel,
    input  logic              we,
    input  logic              word,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        strb,
    output mpy_mode_e         op1_mode,
    output logic              w1_sgn,
    output logic [3:0]        rsel
);
    localparam int N_OP1  = 4;
    localparam int N_PROD = 4;

    logic hit;
    logic wr;
    logic rd;

    always_comb begin
        hit      = sel && word && (addr >= WIN_LO) && (addr <= WIN_HI);
        wr       = hit && we;
        rd       = hit && !we;
        strb     = '0;
        op1_mode = MODE_UMUL;
        w1_sgn   = 1'b0;
        rsel     = RS_NONE;

        for (int k = 0; k < N_OP1; k++) begin
            if (addr == A_OP1 + ADDR_W'(2 * k)) begin
                strb.op1 = wr;
                op1_mode = mpy_mode_e'(2'(k));
                rsel     = rd ? RS_OP1 : RS_NONE;
            end
        end
        if (addr == A_OP2) begin
            strb.op2 = wr;
            rsel     = rd ? RS_OP2 : RS_NONE;
        end
        if (addr == A_RLO) begin
            strb.rlo = wr;
            rsel     = rd ? RS_RLO : RS_NONE;
        end
        if (addr == A_RHI)  rsel = rd ? RS_RHI  : RS_NONE;
        if (addr == A_SUMX) rsel = rd ? RS_SUMX : RS_NONE;
        if (addr == A_W1LOU || addr == A_W1LOS) begin
            strb.w1lo = wr;
            w1_sgn    = (addr == A_W1LOS);
            rsel      = rd ? RS_W1LO : RS_NONE;
        end
        if (addr == A_W1HIU || addr == A_W1HIS) begin
            strb.w1hi = wr;
            rsel      = rd ? RS_W1HI : RS_NONE;
        end
        if (addr == A_W2LO) begin
            strb.w2lo = wr;
            rsel      = rd ? RS_W2LO : RS_NONE;
        end
        if (addr == A_W2HI) begin
            strb.w2hi = wr;
            rsel      = rd ? RS_W2HI : RS_NONE;
        end
        for (int k = 0; k < N_PROD; k++) begin
            if (addr == A_PROD + ADDR_W'(2 * k)) begin
                rsel = rd ? (RS_P0 + 4'(k)) : RS_NONE;
            end
        end
    end

endmodule

// File: rtl/mac_periph_mult.sv
module mac_periph_mult #(
    parameter int IW = 16
) (
    input  logic [IW-1:0]   a,
    input  logic [IW-1:0]   b,
    input  logic            sgn,
    output logic [2*IW-1:0] prod
);
    localparam int OW = 2 * IW;

    logic [OW-1:0] ext_a;
    logic [OW-1:0] ext_b;

    always_comb begin
        ext_a = {{IW{sgn & a[IW-1]}}, a};
        ext_b = {{IW{sgn & b[IW-1]}}, b};
        prod  = ext_a * ext_b;
    end

endmodule

// File: rtl/mac_periph.sv
module mac_periph
    import mac_periph_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                DW      = 16,
    parameter logic [ADDR_W-1:0] WIN_LO  = 16'h0130,
    parameter logic [ADDR_W-1:0] WIN_HI  = 16'h015B,
    parameter logic [ADDR_W-1:0] A_OP1   = 16'h0130,
    parameter logic [ADDR_W-1:0] A_OP2   = 16'h0138,
    parameter logic [ADDR_W-1:0] A_RLO   = 16'h013A,
    parameter logic [ADDR_W-1:0] A_RHI   = 16'h013C,
    parameter logic [ADDR_W-1:0] A_SUMX  = 16'h013E,
    parameter logic [ADDR_W-1:0] A_W1LOU = 16'h0140,
    parameter logic [ADDR_W-1:0] A_W1HIU = 16'h0142,
    parameter logic [ADDR_W-1:0] A_W1LOS = 16'h0144,
    parameter logic [ADDR_W-1:0] A_W1HIS = 16'h0146,
    parameter logic [ADDR_W-1:0] A_W2LO  = 16'h0148,
    parameter logic [ADDR_W-1:0] A_W2HI  = 16'h014A,
    parameter logic [ADDR_W-1:0] A_PROD  = 16'h014C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);
    localparam int RW     = 2 * DW;
    localparam int XW     = 4 * DW;
    localparam int N_PROD = XW / DW;

    typedef struct packed {
        mpy_mode_e     mode;
        logic [DW-1:0] op1;
        logic [DW-1:0] op2;
        logic [RW-1:0] res;
        logic [RW-1:0] acc;
        logic          cy;
        logic          sgn64;
        logic [RW-1:0] w1;
        logic [RW-1:0] w2;
        logic [XW-1:0] p64;
    } state_t;

    state_t st_d;
    state_t st_q;

    wr_strobe_t    strb;
    mpy_mode_e     op1_mode;
    logic          w1_sgn;
    logic [3:0]    rsel;
    logic [RW-1:0] prod16;
    logic [RW:0]   mac_sum;
    logic [RW-1:0] w2_new;
    logic [XW-1:0] prod32;
    logic [RW-1:0] preload;

    // signals the checker watches
    logic [RW-1:0] res_q;
    logic [RW-1:0] acc_q;
    logic [XW-1:0] p64_q;
    logic [1:0]    mode_q;

    mac_periph_decode #(
        .ADDR_W (ADDR_W),  .WIN_LO (WIN_LO),   .WIN_HI (WIN_HI),
        .A_OP1  (A_OP1),   .A_OP2  (A_OP2),    .A_RLO  (A_RLO),
        .A_RHI  (A_RHI),   .A_SUMX (A_SUMX),   .A_W1LOU(A_W1LOU),
        .A_W1HIU(A_W1HIU), .A_W1LOS(A_W1LOS),  .A_W1HIS(A_W1HIS),
        .A_W2LO (A_W2LO),  .A_W2HI (A_W2HI),   .A_PROD (A_PROD)
    ) i_decode (
        .sel     (bus_sel),
        .we      (bus_we),
        .word    (bus_word),
        .addr    (bus_addr),
        .strb    (strb),
        .op1_mode(op1_mode),
        .w1_sgn  (w1_sgn),
        .rsel    (rsel)
    );

    // 16x16 path: operand 2 is taken from the bus in the writing cycle
    mac_periph_mult #(.IW(DW)) i_mult16 (
        .a   (st_q.op1),
        .b   (bus_wdata),
        .sgn (mode_is_signed(st_q.mode)),
        .prod(prod16)
    );

    // 32x32 path: high word of operand 2 comes straight from the bus
    assign w2_new = {bus_wdata, st_q.w2[DW-1:0]};

    mac_periph_mult #(.IW(RW)) i_mult32 (
        .a   (st_q.w1),
        .b   (w2_new),
        .sgn (st_q.sgn64),
        .prod(prod32)
    );

    always_comb begin
        mac_sum = {1'b0, st_q.acc} + {1'b0, prod16};
        preload = {{DW{mode_is_signed(st_q.mode) & bus_wdata[DW-1]}}, bus_wdata};
        st_d    = st_q;

        if (strb.op1) begin
            st_d.op1  = bus_wdata;
            st_d.mode = op1_mode;
        end
        if (strb.op2) begin
            st_d.op2 = bus_wdata;
            if (mode_is_mac(st_q.mode)) begin
                st_d.acc = mac_sum[RW-1:0];
                st_d.res = mac_sum[RW-1:0];
                st_d.cy  = mac_sum[RW];
            end else begin
                st_d.res = prod16;
                st_d.acc = '0;
                st_d.cy  = 1'b0;
            end
        end
        if (strb.rlo) begin
            st_d.res = preload;
            st_d.acc = preload;
            st_d.cy  = 1'b0;
        end
        if (strb.w1lo) begin
            st_d.w1    = {{DW{1'b0}}, bus_wdata};
            st_d.sgn64 = w1_sgn;
        end
        if (strb.w1hi) begin
            st_d.w1[RW-1:DW] = bus_wdata;
        end
        if (strb.w2lo) begin
            st_d.w2 = {{DW{1'b0}}, bus_wdata};
        end
        if (strb.w2hi) begin
            st_d.w2  = w2_new;
            st_d.p64 = prod32;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            RS_OP1:  bus_rdata = st_q.op1;
            RS_OP2:  bus_rdata = st_q.op2;
            RS_RLO:  bus_rdata = st_q.res[DW-1:0];
            RS_RHI:  bus_rdata = st_q.res[RW-1:DW];
            RS_SUMX: begin
                case (st_q.mode)
                    MODE_UMUL: bus_rdata = '0;
                    MODE_SMUL: bus_rdata = {DW{st_q.res[RW-1]}};
                    MODE_UMAC: bus_rdata = {{(DW-1){1'b0}}, st_q.cy};
                    MODE_SMAC: bus_rdata = {DW{st_q.acc[RW-1]}};
                    default:   bus_rdata = '0;
                endcase
            end
            RS_W1LO: bus_rdata = st_q.w1[DW-1:0];
            RS_W1HI: bus_rdata = st_q.w1[RW-1:DW];
            RS_W2LO: bus_rdata = st_q.w2[DW-1:0];
            RS_W2HI: bus_rdata = st_q.w2[RW-1:DW];
            default: begin
                for (int k = 0; k < N_PROD; k++) begin
                    if (rsel == RS_P0 + 4'(k)) begin
                        bus_rdata = st_q.p64[k*DW +: DW];
                    end
                end
            end
        endcase
    end

    assign res_q  = st_q.res;
    assign acc_q  = st_q.acc;
    assign p64_q  = st_q.p64;
    assign mode_q = st_q.mode;

endmodule

// File: rtl/mac_periph_chk.sv
module mac_periph_chk #(
    parameter int                ADDR_W = 16,
    parameter int                DW     = 16,
    parameter logic [ADDR_W-1:0] WIN_LO = 16'h0130,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'h015B,
    parameter logic [ADDR_W-1:0] A_OP1  = 16'h0130,
    parameter logic [ADDR_W-1:0] A_OP2  = 16'h0138,
    parameter logic [ADDR_W-1:0] A_RLO  = 16'h013A,
    parameter logic [ADDR_W-1:0] A_SUMX = 16'h013E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic              bus_word,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [2*DW-1:0]   res_q,
    input logic [2*DW-1:0]   acc_q,
    input logic [4*DW-1:0]   p64_q,
    input logic [1:0]        mode_q
);
    AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_addr < WIN_LO || bus_addr > WIN_HI)) |-> bus_rdata == '0); // R1

    AST_BYTE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_word) |=> ($stable(res_q) && $stable(acc_q) && $stable(p64_q))); // R1

    AST_OP1_SELECTS_UMAC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_word && bus_addr == A_OP1 + ADDR_W'(4)) |=> mode_q == 2'd2); // R2

    AST_MUL_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_word && bus_addr == A_OP2 && !mode_q[1]) |=> acc_q == '0); // R4

    AST_SUMX_UMUL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_word && bus_addr == A_SUMX && mode_q == 2'd0) |-> bus_rdata == '0); // R6

    AST_PRELOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_word && bus_addr == A_RLO)
        |=> (res_q[DW-1:0] == $past(bus_wdata) && acc_q == res_q)); // R7

endmodule

bind mac_periph mac_periph_chk #(
    .ADDR_W(ADDR_W), .DW(DW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .A_OP1(A_OP1), .A_OP2(A_OP2), .A_RLO(A_RLO), .A_SUMX(A_SUMX)
) i_mac_periph_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .res_q    (res_q),
    .acc_q    (acc_q),
    .p64_q    (p64_q),
    .mode_q   (mode_q)
);

// File: tb/test_mac_periph.sv
module test_mac_periph;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mac_periph i_mac_periph (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_word (bus_word),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic word = 1'b1);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0; bus_word = 1'b1;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp,
                          input logic word = 1'b1);
        logic [15:0] got;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word = word; bus_addr = a;
        #2 got = bus_rdata;
        #1 bus_sel = 1'b0; bus_word = 1'b1;
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr %h: got %h expected %h", tag, a, got, exp);
        end
    endtask

    task automatic t_reset();
        rd_chk("R11 reset low", 16'h013A, 16'h0000);
        rd_chk("R11 reset sumext", 16'h013E, 16'h0000);
        rd_chk("R11 reset prod0", 16'h014C, 16'h0000);
    endtask

    task automatic t_umul();
        wr(16'h0130, 16'hFFFF);
        wr(16'h0138, 16'hFFFF);
        rd_chk("R3 R4 umul low", 16'h013A, 16'h0001);
        rd_chk("R3 R4 umul high", 16'h013C, 16'hFFFE);
        rd_chk("R6 umul sumext", 16'h013E, 16'h0000);
        rd_chk("R2 op1 readback", 16'h0132, 16'hFFFF);
    endtask

    task automatic t_smul_then_mac();
        wr(16'h0132, 16'hFFFF);
        wr(16'h0138, 16'h0003);
        rd_chk("R4 smul low", 16'h013A, 16'hFFFD);
        rd_chk("R4 smul high", 16'h013C, 16'hFFFF);
        rd_chk("R6 smul sumext", 16'h013E, 16'hFFFF);
        wr(16'h0134, 16'h0002);
        wr(16'h0138, 16'h0003);
        rd_chk("R5 mac after mul clears acc low", 16'h013A, 16'h0006);
        rd_chk("R5 mac after mul high", 16'h013C, 16'h0000);
    endtask

    task automatic t_umac_carry();
        wr(16'h0134, 16'hFFFF);
        wr(16'h0138, 16'hFFFF);
        rd_chk("R5 umac1 high", 16'h013C, 16'hFFFE);
        rd_chk("R6 umac no carry", 16'h013E, 16'h0000);
        wr(16'h0138, 16'hFFFF);
        rd_chk("R5 umac2 low", 16'h013A, 16'h0008);
        rd_chk("R5 umac2 high wrapped", 16'h013C, 16'hFFFC);
        rd_chk("R6 umac carry", 16'h013E, 16'h0001);
    endtask

    task automatic t_smac_preload();
        wr(16'h0136, 16'hFFFE);
        wr(16'h013A, 16'h0005);
        rd_chk("R7 preload low", 16'h013A, 16'h0005);
        wr(16'h0138, 16'h0004);
        rd_chk("R5 smac low", 16'h013A, 16'hFFFD);
        rd_chk("R5 smac high", 16'h013C, 16'hFFFF);
        rd_chk("R6 smac sumext", 16'h013E, 16'hFFFF);
        wr(16'h013A, 16'h8000);
        rd_chk("R7 signed preload high", 16'h013C, 16'hFFFF);
        wr(16'h0130, 16'h0001);
        wr(16'h013A, 16'h8000);
        rd_chk("R7 unsigned preload high", 16'h013C, 16'h0000);
    endtask

    task automatic t_ignored();
        wr(16'h013A, 16'h1234, 1'b0);
        rd_chk("R1 byte write ignored", 16'h013A, 16'h8000);
        rd_chk("R1 byte read zero", 16'h013A, 16'h0000, 1'b0);
        wr(16'h012E, 16'h7777);
        rd_chk("R1 outside read zero", 16'h012E, 16'h0000);
        rd_chk("R1 outside write ignored", 16'h013A, 16'h8000);
        rd_chk("R10 unmapped read", 16'h0154, 16'h0000);
        wr(16'h013C, 16'h5555);
        rd_chk("R10 high write ignored", 16'h013C, 16'h0000);
        wr(16'h013E, 16'h5555);
        rd_chk("R10 sumext write ignored", 16'h013A, 16'h8000);
    endtask

    task automatic t_wide();
        wr(16'h0140, 16'hFFFF);
        wr(16'h0142, 16'hFFFF);
        wr(16'h0148, 16'hFFFF);
        wr(16'h014A, 16'hFFFF);
        rd_chk("R9 u64 w0", 16'h014C, 16'h0001);
        rd_chk("R9 u64 w1", 16'h014E, 16'h0000);
        rd_chk("R9 u64 w2", 16'h0150, 16'hFFFE);
        rd_chk("R9 u64 w3", 16'h0152, 16'hFFFF);
        wr(16'h0144, 16'hFFFF);
        wr(16'h0146, 16'hFFFF);
        wr(16'h0148, 16'h0002);
        rd_chk("R8 op2 low clears high", 16'h014A, 16'h0000);
        rd_chk("R9 product held until high write", 16'h014C, 16'h0001);
        wr(16'h014A, 16'h0000);
        rd_chk("R9 s64 w0", 16'h014C, 16'hFFFE);
        rd_chk("R9 s64 w1", 16'h014E, 16'hFFFF);
        rd_chk("R9 s64 w3", 16'h0152, 16'hFFFF);
        wr(16'h0144, 16'h0003);
        rd_chk("R8 op1 low clears high", 16'h0146, 16'h0000);
        wr(16'h0148, 16'h0005);
        wr(16'h014A, 16'h0000);
        rd_chk("R9 s64 small w0", 16'h014C, 16'h000F);
        rd_chk("R9 s64 small w3", 16'h0152, 16'h0000);
        wr(16'h014C, 16'h1111);
        rd_chk("R10 product write ignored", 16'h014C, 16'h000F);
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_umul();
        t_smul_then_mac();
        t_umac_carry();
        t_smac_preload();
        t_ignored();
        t_wide();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule